// File: doc/BRIEF.md
# Pixel Trigger Latency Buffer

This block keeps a short history of hit flags for every pixel of a small detector matrix, one flag per bunch-crossing clock, so that a level-1 trigger that arrives a fixed number of crossings later can decide whether a hit is kept or dropped. Each pixel owns a ring of `DEPTH` one-bit cells. A single write pointer, shared by the whole matrix, stores the current hit flag in one cell on every clock. In the same clock, the cell just ahead of the pointer is copied into a registered read stage. That cell is the oldest entry in the ring.

When the delayed flag in the read stage meets an asserted trigger, a per-pixel set/reset latch captures the confirmed hit. The latch keeps it until a clear or a reset. The latch outputs of a row are ORed together onto one fast line per row, and the latch outputs of a column onto one fast line per column. Readout logic uses these lines to locate confirmed hits. Pixel `p` sits at row `p / COLS` and column `p % COLS`.

Top module: `trig_latency_matrix`

## Requirements
- R1: A synchronous reset clears every latch, every fast-OR line and every buffer cell, so that a hit sampled before the reset can never be confirmed after it.
- R2: The hit flag is stored on every clock whether it is 1 or 0, so a hit that has not been confirmed is overwritten after one full turn of the ring. A trigger at `2*DEPTH` cycles after the hit finds nothing.
- R3: A hit sampled at clock edge n is confirmed only by a trigger sampled at edge n+DEPTH. A trigger at n+DEPTH-1 or n+DEPTH+1 does not confirm it.
- R4: The write pointer steps by one on every clock and wraps from `DEPTH-1` to 0, giving the same latency on every turn of the ring.
- R5: A confirmed hit sets its pixel latch at the trigger edge, so `latched_o[p]` is 1 right after that edge. The latch then stays 1 through any later cycles, with or without triggers, until a clear or a reset.
- R6: `clr_i` clears every latch on the next edge and has priority over a coincidence that would set a latch in the same cycle.
- R7: `row_or_o[r]` is the OR of the latches in row r, and `col_or_o[c]` is the OR of the latches in column c, with pixel p = r*COLS + c.
- R8: The trigger and the pointer are common to all pixels. One trigger confirms every pixel hit in the matching crossing and no pixel hit in a different crossing.
- R9: A trigger with no buffered hit in the matching crossing sets no latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | ROWS*COLS | Per-pixel hit flag for the current crossing |
| l1_trig_i | input | 1 | Level-1 trigger, common to all pixels |
| clr_i | input | 1 | Clears all hit latches |
| latched_o | output | ROWS*COLS | Per-pixel confirmed-hit latch |
| row_or_o | output | ROWS | Fast OR of the latches in each row |
| col_or_o | output | COLS | Fast OR of the latches in each column |

## Verification
A pointer that skips or wraps at the wrong cell moves the crossing that a trigger sees. The symptom is that a latch which should set after exactly DEPTH cycles stays low, or a latch sets one cycle early or late, on the first turn that crosses the fault. A cell that is not rewritten with zeros leaves a stale hit behind, and a trigger one full turn later then sets a latch it should not. A latch that loses its value, or a clear with the wrong priority, shows on `latched_o` and on both fast-OR lines one clock after the trigger or the clear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // next ring index with wrap for any depth
   function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
      return (idx == depth - 1) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/tlb_ptr.sv
module tlb_ptr #(
   parameter int DEPTH = 120,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx
);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   generate
      if (POW2) begin : g_pow2
         // natural binary wrap
         always_ff @(posedge clk) begin
            if (rst) wr_idx <= '0;
            else     wr_idx <= wr_idx + 1'b1;
         end
         assign rd_idx = wr_idx + 1'b1;
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst) wr_idx <= '0;
            else     wr_idx <= AW'(tlb_pkg::wrap_inc(32'(wr_idx), DEPTH));
         end
         assign rd_idx = AW'(tlb_pkg::wrap_inc(32'(wr_idx), DEPTH));
      end
   endgenerate
endmodule

// File: rtl/tlb_pixel.sv
module tlb_pixel #(
   parameter int DEPTH = 120,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] wr_idx,
   input  logic [AW-1:0] rd_idx,
   input  logic          hit,
   input  logic          trig,
   input  logic          clr,
   output logic          latched
);
   logic [DEPTH-1:0] cells;
   logic             rd_q;

   // ring write and read of the cell ahead, every crossing
   always_ff @(posedge clk) begin
      if (rst) begin
         cells <= '0;
         rd_q  <= 1'b0;
      end else begin
         cells[wr_idx] <= hit;
         rd_q          <= cells[rd_idx];
      end
   end

   // set/reset hit latch, clear dominant
   always_ff @(posedge clk) begin
      if (rst || clr)       latched <= 1'b0;
      else if (rd_q && trig) latched <= 1'b1;
   end
endmodule

// File: rtl/tlb_fast_or.sv
module tlb_fast_or #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int NPIX = ROWS * COLS
) (
   input  logic [NPIX-1:0] pix,
   output logic [ROWS-1:0] row_or,
   output logic [COLS-1:0] col_or
);
   genvar r, c;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         assign row_or[r] = |pix[r*COLS +: COLS];
      end
      for (c = 0; c < COLS; c++) begin : g_col
         logic [ROWS-1:0] colbits;
         for (r = 0; r < ROWS; r++) begin : g_tap
            assign colbits[r] = pix[r*COLS + c];
         end
         assign col_or[c] = |colbits;
      end
   endgenerate
endmodule

// File: rtl/trig_latency_matrix.sv
module trig_latency_matrix #(
   parameter int DEPTH = 120,
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   localparam int NPIX = ROWS * COLS,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NPIX-1:0] hit_i,
   input  logic            l1_trig_i,
   input  logic            clr_i,
   output logic [NPIX-1:0] latched_o,
   output logic [ROWS-1:0] row_or_o,
   output logic [COLS-1:0] col_or_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (ROWS < 1 || COLS < 1) begin : g_bad_size
         $error("ROWS and COLS must be at least 1");
      end
   endgenerate

   logic [AW-1:0] wr_idx, rd_idx;

   tlb_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst(rst), .wr_idx(wr_idx), .rd_idx(rd_idx)
   );

   genvar p;
   generate
      for (p = 0; p < NPIX; p++) begin : g_pix
         tlb_pixel #(.DEPTH(DEPTH)) u_pix (
            .clk(clk), .rst(rst), .wr_idx(wr_idx), .rd_idx(rd_idx),
            .hit(hit_i[p]), .trig(l1_trig_i), .clr(clr_i),
            .latched(latched_o[p])
         );
      end
   endgenerate

   tlb_fast_or #(.ROWS(ROWS), .COLS(COLS)) u_or (
      .pix(latched_o), .row_or(row_or_o), .col_or(col_or_o)
   );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
   parameter int DEPTH = 120,
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   localparam int NPIX = ROWS * COLS,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic            clk,
   input logic            rst,
   input logic            l1_trig_i,
   input logic            clr_i,
   input logic [AW-1:0]   wr_idx,
   input logic [NPIX-1:0] latched_o,
   input logic [ROWS-1:0] row_or_o,
   input logic [COLS-1:0] col_or_o
);
   logic [ROWS-1:0] row_exp;
   logic [COLS-1:0] col_exp;

   always_comb begin
      row_exp = '0;
      col_exp = '0;
      for (int i = 0; i < NPIX; i++) begin
         row_exp[i / COLS] = row_exp[i / COLS] | latched_o[i];
         col_exp[i % COLS] = col_exp[i % COLS] | latched_o[i];
      end
   end

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(wr_idx) != DEPTH - 1) |=> (32'(wr_idx) == 32'($past(wr_idx)) + 1));

   // R4
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (32'(wr_idx) == DEPTH - 1) |=> (wr_idx == '0));

   // R6
   clear_chk: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (latched_o == '0));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !clr_i |=> ((latched_o & $past(latched_o)) == $past(latched_o)));

   // R9
   set_needs_trig_chk: assert property (@(posedge clk) disable iff (rst)
      ((latched_o & ~$past(latched_o)) != '0) |-> $past(l1_trig_i));

   // R7
   fast_or_chk: assert property (@(posedge clk) disable iff (rst)
      (row_or_o == row_exp) && (col_or_o == col_exp));
endmodule

bind trig_latency_matrix tlb_checker #(.DEPTH(DEPTH), .ROWS(ROWS), .COLS(COLS)) u_chk (
   .clk(clk), .rst(rst), .l1_trig_i(l1_trig_i), .clr_i(clr_i),
   .wr_idx(u_ptr.wr_idx), .latched_o(latched_o),
   .row_or_o(row_or_o), .col_or_o(col_or_o)
);

// File: tb/test_trig_latency_matrix.sv
module test_trig_latency_matrix;
   localparam int DEPTH = 120;
   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int NPIX  = ROWS * COLS;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NPIX-1:0] hit_i = '0;
   logic            l1_trig_i = 1'b0;
   logic            clr_i = 1'b0;
   logic [NPIX-1:0] latched_o;
   logic [ROWS-1:0] row_or_o;
   logic [COLS-1:0] col_or_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   always #2.5 clk = ~clk;

   trig_latency_matrix #(.DEPTH(DEPTH), .ROWS(ROWS), .COLS(COLS)) i_trig_latency_matrix (
      .clk(clk), .rst(rst), .hit_i(hit_i), .l1_trig_i(l1_trig_i), .clr_i(clr_i),
      .latched_o(latched_o), .row_or_o(row_or_o), .col_or_o(col_or_o)
   );

   // {pixel, trigger offset, expect set}
   localparam int VEC [8][3] = '{
      '{0,  DEPTH,     1},
      '{5,  DEPTH - 1, 0},
      '{5,  DEPTH + 1, 0},
      '{9,  DEPTH,     1},
      '{15, DEPTH,     1},
      '{3,  2 * DEPTH, 0},
      '{12, DEPTH,     1},
      '{6,  DEPTH + 1, 0}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req, input logic [NPIX-1:0] exp_pix);
      logic [ROWS-1:0] er = '0;
      logic [COLS-1:0] ec = '0;
      for (int i = 0; i < NPIX; i++) begin
         if (exp_pix[i]) begin
            er[i / COLS] = 1'b1;
            ec[i % COLS] = 1'b1;
         end
      end
      check(req, int'(latched_o), int'(exp_pix));
      check({req, "/R7 row"}, int'(row_or_o), int'(er));
      check({req, "/R7 col"}, int'(col_or_o), int'(ec));
   endtask

   task automatic pulse_clear();
      @(negedge clk); clr_i = 1'b1;
      @(negedge clk); clr_i = 1'b0;
   endtask

   // hit on a pixel mask, trigger sampled exactly off edges later
   task automatic hit_then_trig(input logic [NPIX-1:0] mask, input int off);
      @(negedge clk); hit_i = mask;
      @(negedge clk); hit_i = '0;
      repeat (off - 1) @(negedge clk);
      l1_trig_i = 1'b1;
      @(negedge clk); l1_trig_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check_outputs("R1 reset state", '0);

      // R3 R2 vector table
      foreach (VEC[v]) begin
         pulse_clear();
         hit_then_trig(NPIX'(1) << VEC[v][0], VEC[v][1]);
         check_outputs("R3/R2 latency vector",
                       VEC[v][2] ? (NPIX'(1) << VEC[v][0]) : '0);
      end

      // R9 trigger with empty buffer
      pulse_clear();
      @(negedge clk); l1_trig_i = 1'b1;
      @(negedge clk); l1_trig_i = 1'b0;
      check_outputs("R9 trigger without hit", '0);

      // R8 shared trigger: pixels 0 and 5 in one crossing, 10 one later
      pulse_clear();
      @(negedge clk); hit_i = NPIX'(16'h0021);
      @(negedge clk); hit_i = NPIX'(16'h0400);
      @(negedge clk); hit_i = '0;
      repeat (DEPTH - 2) @(negedge clk);
      l1_trig_i = 1'b1;
      @(negedge clk); l1_trig_i = 1'b0;
      check_outputs("R8 common trigger", NPIX'(16'h0021));

      // R5 hold through later triggers
      @(negedge clk); l1_trig_i = 1'b1;
      repeat (10) @(negedge clk);
      l1_trig_i = 1'b0;
      check_outputs("R5 latch holds", NPIX'(16'h0021));

      // R6 clear
      pulse_clear();
      check_outputs("R6 clear all", '0);

      // R6 clear priority over coincidence
      @(negedge clk); hit_i = NPIX'(16'h0020);
      @(negedge clk); hit_i = '0;
      repeat (DEPTH - 1) @(negedge clk);
      l1_trig_i = 1'b1; clr_i = 1'b1;
      @(negedge clk); l1_trig_i = 1'b0; clr_i = 1'b0;
      check_outputs("R6 clear priority", '0);

      // R1 reset drops buffered hit
      @(negedge clk); hit_i = NPIX'(16'h0080);
      @(negedge clk); hit_i = '0;
      repeat (9) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (DEPTH - 12) @(negedge clk);
      l1_trig_i = 1'b1;
      @(negedge clk); l1_trig_i = 1'b0;
      check_outputs("R1 reset flushes buffer", '0);

      // R4 latency still exact after many wraps
      repeat (3 * DEPTH + 7) @(negedge clk);
      hit_then_trig(NPIX'(16'h8000), DEPTH);
      check_outputs("R4 latency after wraps", NPIX'(16'h8000));

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule